// File: doc/BRIEF.md
# CAN Status and Error-State Unit

This unit holds the software-visible status side of a CAN controller: the control register, the status register with its last-error-code field, the error counter register and the interrupt identifier register. A protocol engine next to it loads new transmit and receive error counts, pulses a strobe when a frame is sent or received correctly, and reports the code of each bus error. The unit turns the counts into warning, passive and bus-off flags. It raises a status interrupt when the error state changes or when an enabled event occurs.

Software finds the cause of an interrupt by reading the interrupt identifier. A pending status event always reads back as 0x8000. Otherwise the identifier shows the number of the message object that a neighbouring message handler reports as pending, or zero. Software arms the last-error-code field by writing 7 into it. Because 7 is never produced by the engine for a real event, a value other than 7 shows that a bus event occurred after the write. Reading the status register acknowledges the status interrupt.

Top module: `can_status_unit`

## Requirements
- R1: The control register is at address 0 and resets to 0x0001. Software can write bits 7, 6, 5, 3, 2, 1 and 0; bit 4 always reads 0. Bit 3 enables error interrupts, bit 2 enables status interrupts, bit 1 is the master interrupt enable and bit 0 is init.
- R2: The status register is at address 1 and reads {busOff, warn, passive, rxOk, txOk, lec[2:0]} in bits 7..0. It resets to 0. A strobe sets txOk or rxOk. A last-error-code event loads its code into bits 2:0.
- R3: A CPU write to the status register loads bits 2:0 into the last-error-code field, so writing 7 arms the sentinel. A write clears rxOk or txOk only where the written bit is 0; a written 1 leaves the bit unchanged.
- R4: The error counter register is at address 2. It reads the low 8 bits of the transmit count in bits 7:0 and the low 7 bits of the receive count in bits 14:8. Bit 15 is 1 when the receive count is greater than 127.
- R5: The warning flag is 1 when either count is 96 or more. The passive flag is 1 when either count is greater than 127.
- R6: The bus-off flag is 1 when the transmit count is greater than 255. Entering bus-off sets the init bit, and this takes priority over a CPU write in the same cycle.
- R7: Any change of the busOff, warn or passive flags requests a status interrupt one cycle after the counters load.
- R8: A last-error-code event with a code from 1 to 6 requests a status interrupt only while bit 3 is set. Codes 0 and 7 never request one.
- R9: A txOk or rxOk strobe requests a status interrupt only while bit 2 is set.
- R10: Reading the status register clears the pending status interrupt. A new request in the same cycle wins.
- R11: The interrupt register is at address 3. It reads 0x8000 while a status interrupt is pending, otherwise the pending object number, or 0 when nothing is pending.
- R12: irqOut is 1 exactly when bit 1 of the control register is set and the interrupt register is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuSel | input | 1 | CPU access strobe |
| cpuWr | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | 2 | Register select (0 control, 1 status, 2 error counts, 3 interrupt) |
| cpuWdata | input | 8 | Write data |
| cpuRdata | output | 16 | Read data of the selected register |
| errUpd | input | 1 | Load new error counts |
| txErrIn | input | 9 | New transmit error count |
| rxErrIn | input | 8 | New receive error count |
| txOkEv | input | 1 | Frame transmitted correctly |
| rxOkEv | input | 1 | Frame received correctly |
| lecEv | input | 1 | Bus error code valid |
| lecCode | input | 3 | Bus error code (0 none, 1 stuff, 2 form, 3 ack, 4 bit-1, 5 bit-0, 6 CRC) |
| pendObj | input | 6 | Number of the pending message object, 0 if none |
| ctrlOut | output | 8 | Control register contents, for the protocol engine |
| irqOut | output | 1 | Interrupt request |

## Verification
Stale previous-state flags would show up as a missing or spurious 0x8000 in the interrupt register two cycles after a counter load. A broken acknowledge would leave irqOut high after the status read. Wrong threshold or field decoding appears at once in the next status or error counter read. A lost bus-off override appears as init reading 0 on the control register two cycles after the count passes 255. The sequence deliberately includes loads that leave the flags unchanged, so that a spurious interrupt becomes visible.

// File: rtl/canstat_pkg.sv
package canstat_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_ERRC = 2'd2,
    REG_INTR = 2'd3
  } regSel_e;

  typedef struct packed {
    logic busOff;
    logic warn;
    logic passive;
  } errFlags_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       wrStatus;
    logic [7:0] wrData;
  } dpCmd_t;

  localparam logic [7:0]  CTRL_WMASK      = 8'hEF;
  localparam logic [7:0]  CTRL_RESET      = 8'h01;
  localparam logic [15:0] STATUS_IRQ_CODE = 16'h8000;
  localparam logic [2:0]  LEC_NONE        = 3'd0;
  localparam logic [2:0]  LEC_SENTINEL    = 3'd7;
endpackage

// File: rtl/canstat_dp.sv
module canstat_dp
  import canstat_pkg::*;
#(
  parameter int TXC_W    = 9,
  parameter int RXC_W    = 8,
  parameter int WARN_LVL = 96,
  parameter int PASS_LVL = 127,
  parameter int BOFF_LVL = 255
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  logic             errUpd,
  input  logic [TXC_W-1:0] txErrIn,
  input  logic [RXC_W-1:0] rxErrIn,
  input  logic             txOkEv,
  input  logic             rxOkEv,
  input  logic             lecEv,
  input  logic [2:0]       lecCode,
  output errFlags_t        flags,
  output logic [7:0]       statusByte,
  output logic [15:0]      errWord
);
  localparam logic [TXC_W-1:0] TX_WARN = TXC_W'(WARN_LVL);
  localparam logic [TXC_W-1:0] TX_PASS = TXC_W'(PASS_LVL);
  localparam logic [TXC_W-1:0] TX_BOFF = TXC_W'(BOFF_LVL);
  localparam logic [RXC_W-1:0] RX_WARN = RXC_W'(WARN_LVL);
  localparam logic [RXC_W-1:0] RX_PASS = RXC_W'(PASS_LVL);

  logic [TXC_W-1:0] txCnt;
  logic [RXC_W-1:0] rxCnt;
  logic             txOk, rxOk;
  logic [2:0]       lec;
  logic             rxPassive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txCnt <= '0;
      rxCnt <= '0;
    end else if (errUpd) begin
      txCnt <= txErrIn;
      rxCnt <= rxErrIn;
    end
  end

  // engine events take priority over CPU writes in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txOk <= 1'b0;
      rxOk <= 1'b0;
      lec  <= LEC_NONE;
    end else begin
      if (txOkEv)                               txOk <= 1'b1;
      else if (cmd.wrStatus && !cmd.wrData[3])  txOk <= 1'b0;
      if (rxOkEv)                               rxOk <= 1'b1;
      else if (cmd.wrStatus && !cmd.wrData[4])  rxOk <= 1'b0;
      if (lecEv)                                lec  <= lecCode;
      else if (cmd.wrStatus)                    lec  <= cmd.wrData[2:0];
    end
  end

  always_comb begin
    rxPassive     = rxCnt > RX_PASS;
    flags.busOff  = txCnt > TX_BOFF;
    flags.warn    = (txCnt >= TX_WARN) || (rxCnt >= RX_WARN);
    flags.passive = (txCnt > TX_PASS) || rxPassive;
    statusByte    = {flags.busOff, flags.warn, flags.passive, rxOk, txOk, lec};
    errWord       = {rxPassive, rxCnt[6:0], txCnt[7:0]};
  end
endmodule

// File: rtl/canstat_ctrl.sv
module canstat_ctrl
  import canstat_pkg::*;
#(
  parameter int OBJ_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuSel,
  input  logic             cpuWr,
  input  logic [1:0]       cpuAddr,
  input  logic [7:0]       cpuWdata,
  input  errFlags_t        flags,
  input  logic [7:0]       statusByte,
  input  logic [15:0]      errWord,
  input  logic             txOkEv,
  input  logic             rxOkEv,
  input  logic             lecEv,
  input  logic [2:0]       lecCode,
  input  logic [OBJ_W-1:0] pendObj,
  output dpCmd_t           cmd,
  output logic [7:0]       ctrlReg,
  output logic             stsPend,
  output logic [15:0]      intrCode,
  output logic [15:0]      cpuRdata,
  output logic             irqOut
);
  localparam int PAD_W = 16 - OBJ_W;

  errFlags_t  prevFlags;
  logic       wrCtrl, wrStat, rdStat;
  logic       errIe, stsIe, modIe;
  logic       lecHit, okHit, stateHit, boffRise, stsSet;
  logic [7:0] ctrlNext;

  always_comb begin
    wrCtrl   = cpuSel && cpuWr && (cpuAddr == REG_CTRL);
    wrStat   = cpuSel && cpuWr && (cpuAddr == REG_STAT);
    rdStat   = cpuSel && !cpuWr && (cpuAddr == REG_STAT);
    errIe    = ctrlReg[3];
    stsIe    = ctrlReg[2];
    modIe    = ctrlReg[1];
    lecHit   = lecEv && errIe && (lecCode != LEC_NONE) && (lecCode != LEC_SENTINEL);
    okHit    = (txOkEv || rxOkEv) && stsIe;
    stateHit = flags != prevFlags;
    boffRise = flags.busOff && !prevFlags.busOff;
    stsSet   = lecHit || okHit || stateHit;
    ctrlNext = wrCtrl ? (cpuWdata & CTRL_WMASK) : ctrlReg;
    if (boffRise) ctrlNext[0] = 1'b1;
    cmd.wrStatus = wrStat;
    cmd.wrData   = cpuWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevFlags <= '0;
      ctrlReg   <= CTRL_RESET;
      stsPend   <= 1'b0;
    end else begin
      prevFlags <= flags;
      ctrlReg   <= ctrlNext;
      if (stsSet)      stsPend <= 1'b1;
      else if (rdStat) stsPend <= 1'b0;
    end
  end

  always_comb begin
    intrCode = stsPend ? STATUS_IRQ_CODE : {{PAD_W{1'b0}}, pendObj};
    irqOut   = modIe && (intrCode != 16'h0000);
    case (regSel_e'(cpuAddr))
      REG_CTRL: cpuRdata = {8'h00, ctrlReg};
      REG_STAT: cpuRdata = {8'h00, statusByte};
      REG_ERRC: cpuRdata = errWord;
      default:  cpuRdata = intrCode;
    endcase
  end
endmodule

// File: rtl/can_status_unit.sv
module can_status_unit
  import canstat_pkg::*;
#(
  parameter int TXC_W    = 9,
  parameter int RXC_W    = 8,
  parameter int OBJ_W    = 6,
  parameter int WARN_LVL = 96,
  parameter int PASS_LVL = 127,
  parameter int BOFF_LVL = 255
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuSel,
  input  logic             cpuWr,
  input  logic [1:0]       cpuAddr,
  input  logic [7:0]       cpuWdata,
  output logic [15:0]      cpuRdata,
  input  logic             errUpd,
  input  logic [TXC_W-1:0] txErrIn,
  input  logic [RXC_W-1:0] rxErrIn,
  input  logic             txOkEv,
  input  logic             rxOkEv,
  input  logic             lecEv,
  input  logic [2:0]       lecCode,
  input  logic [OBJ_W-1:0] pendObj,
  output logic [7:0]       ctrlOut,
  output logic             irqOut
);
  dpCmd_t      cmdW;
  errFlags_t   flagsW;
  logic [7:0]  statusW;
  logic [15:0] errWordW;
  logic        stsPendW;
  logic [15:0] intrCodeW;

  canstat_dp #(
    .TXC_W(TXC_W), .RXC_W(RXC_W), .WARN_LVL(WARN_LVL),
    .PASS_LVL(PASS_LVL), .BOFF_LVL(BOFF_LVL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmdW),
    .errUpd(errUpd), .txErrIn(txErrIn), .rxErrIn(rxErrIn),
    .txOkEv(txOkEv), .rxOkEv(rxOkEv), .lecEv(lecEv), .lecCode(lecCode),
    .flags(flagsW), .statusByte(statusW), .errWord(errWordW)
  );

  canstat_ctrl #(.OBJ_W(OBJ_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWr(cpuWr),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .flags(flagsW), .statusByte(statusW), .errWord(errWordW),
    .txOkEv(txOkEv), .rxOkEv(rxOkEv), .lecEv(lecEv), .lecCode(lecCode),
    .pendObj(pendObj), .cmd(cmdW), .ctrlReg(ctrlOut), .stsPend(stsPendW),
    .intrCode(intrCodeW), .cpuRdata(cpuRdata), .irqOut(irqOut)
  );
endmodule

// File: rtl/canstat_chk.sv
module canstat_chk
  import canstat_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input errFlags_t   stFlags,
  input logic [7:0]  ctrlReg,
  input logic        stsPend,
  input logic [15:0] intrCode,
  input logic        irqOut
);
  AST_BOFF_SETS_INIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stFlags.busOff) |=> ctrlReg[0]); // R6
  AST_PASSIVE_HAS_WARN: assert property (@(posedge clk) disable iff (!rstN)
    stFlags.passive |-> stFlags.warn); // R5
  AST_STATE_CHANGE_PENDS: assert property (@(posedge clk) disable iff (!rstN)
    (stFlags != $past(stFlags)) |=> stsPend); // R7
  AST_STATUS_CODE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    stsPend |-> (intrCode == STATUS_IRQ_CODE)); // R11
  AST_IRQ_NEEDS_MIE: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ctrlReg[1]); // R12
  AST_PENDING_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (stsPend && ctrlReg[1]) |-> irqOut); // R12
endmodule

bind can_status_unit canstat_chk u_chk (
  .clk(clk), .rstN(rstN), .stFlags(flagsW), .ctrlReg(ctrlOut),
  .stsPend(stsPendW), .intrCode(intrCodeW), .irqOut(irqOut)
);

// File: tb/can_status_unit_bench.sv
`timescale 1ns/1ps
module can_status_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuSel = 1'b0, cpuWr = 1'b0;
  logic [1:0]  cpuAddr = '0;
  logic [7:0]  cpuWdata = '0;
  logic [15:0] cpuRdata;
  logic        errUpd = 1'b0;
  logic [8:0]  txErrIn = '0;
  logic [7:0]  rxErrIn = '0;
  logic        txOkEv = 1'b0, rxOkEv = 1'b0, lecEv = 1'b0;
  logic [2:0]  lecCode = '0;
  logic [5:0]  pendObj = '0;
  logic [7:0]  ctrlOut;
  logic        irqOut;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  typedef struct {
    int          kind;   // 0 = read data, 1 = irq level
    logic [15:0] exp;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  can_status_unit u_can_status_unit (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWr(cpuWr), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .errUpd(errUpd), .txErrIn(txErrIn),
    .rxErrIn(rxErrIn), .txOkEv(txOkEv), .rxOkEv(rxOkEv), .lecEv(lecEv),
    .lecCode(lecCode), .pendObj(pendObj), .ctrlOut(ctrlOut), .irqOut(irqOut)
  );

  // monitor: compare every queued expectation half a cycle after drive
  always @(negedge clk) begin
    while (expQ.size() > 0) begin
      expItem_t it;
      logic [15:0] act;
      it = expQ.pop_front();
      act = (it.kind == 0) ? cpuRdata : {15'd0, irqOut};
      compared++;
      if (act !== it.exp) begin
        mismatched++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  task automatic rd(input logic [1:0] a, input logic [15:0] e, input string tag);
    @(posedge clk); #1;
    cpuSel = 1'b1; cpuWr = 1'b0; cpuAddr = a;
    expQ.push_back('{0, e, tag});
    @(posedge clk); #1;
    cpuSel = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    cpuSel = 1'b1; cpuWr = 1'b1; cpuAddr = a; cpuWdata = d;
    @(posedge clk); #1;
    cpuSel = 1'b0; cpuWr = 1'b0;
  endtask

  task automatic chkIrq(input logic e, input string tag);
    @(posedge clk); #1;
    expQ.push_back('{1, {15'd0, e}, tag});
  endtask

  task automatic okPulse(input bit tx);
    @(posedge clk); #1;
    if (tx) txOkEv = 1'b1; else rxOkEv = 1'b1;
    @(posedge clk); #1;
    txOkEv = 1'b0; rxOkEv = 1'b0;
  endtask

  task automatic lecPulse(input logic [2:0] c);
    @(posedge clk); #1;
    lecEv = 1'b1; lecCode = c;
    @(posedge clk); #1;
    lecEv = 1'b0;
  endtask

  task automatic counts(input logic [8:0] t, input logic [7:0] r);
    @(posedge clk); #1;
    errUpd = 1'b1; txErrIn = t; rxErrIn = r;
    @(posedge clk); #1;
    errUpd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // reset state
    rd(2'd0, 16'h0001, "R1 ctrl reset");
    rd(2'd1, 16'h0000, "R2 status reset");
    rd(2'd2, 16'h0000, "R4 errcnt reset");
    rd(2'd3, 16'h0000, "R11 intr reset");
    chkIrq(1'b0, "R12 irq reset");
    // control register
    wr(2'd0, 8'hFF);
    rd(2'd0, 16'h00EF, "R1 bit4 reads zero");
    wr(2'd0, 8'h0E);
    rd(2'd0, 16'h000E, "R1 ctrl write");
    // tx ok interrupt and acknowledge
    okPulse(1'b1);
    rd(2'd3, 16'h8000, "R9 txOk raises status code");
    chkIrq(1'b1, "R12 irq with pending status");
    rd(2'd1, 16'h0008, "R2 txOk bit");
    rd(2'd3, 16'h0000, "R10 status read clears");
    chkIrq(1'b0, "R10 irq drops after read");
    // write semantics of status
    okPulse(1'b0);
    wr(2'd1, 8'hFF);
    rd(2'd1, 16'h001F, "R3 writing ones keeps ok bits, lec=7");
    wr(2'd1, 8'h07);
    rd(2'd1, 16'h0007, "R3 writing zeros clears ok bits");
    rd(2'd3, 16'h0000, "R10 cleared after status reads");
    // pending message object and master enable
    pendObj = 6'd5;
    rd(2'd3, 16'h0005, "R11 object number");
    chkIrq(1'b1, "R12 irq from object");
    wr(2'd0, 8'h0C);
    chkIrq(1'b0, "R12 irq masked by MIE");
    wr(2'd0, 8'h0E);
    okPulse(1'b1);
    rd(2'd3, 16'h8000, "R11 status beats object");
    rd(2'd1, 16'h000F, "R2 txOk with lec 7");
    pendObj = 6'd0;
    wr(2'd1, 8'h07);
    // last error codes
    lecPulse(3'd3);
    rd(2'd3, 16'h8000, "R8 ack error raises");
    rd(2'd1, 16'h0003, "R2 lec ack captured");
    lecPulse(3'd0);
    rd(2'd3, 16'h0000, "R8 code 0 silent");
    rd(2'd1, 16'h0000, "R2 lec none captured");
    lecPulse(3'd7);
    rd(2'd3, 16'h0000, "R8 code 7 silent");
    wr(2'd0, 8'h06);
    lecPulse(3'd2);
    rd(2'd3, 16'h0000, "R8 EIE off silent");
    rd(2'd1, 16'h0002, "R2 lec form captured");
    wr(2'd0, 8'h0A);
    okPulse(1'b1);
    rd(2'd3, 16'h0000, "R9 SIE off silent");
    rd(2'd1, 16'h000A, "R2 txOk set with SIE off");
    wr(2'd1, 8'h02);
    wr(2'd0, 8'h0E);
    // counters and error state
    counts(9'd96, 8'd0);
    rd(2'd3, 16'h8000, "R7 warn entry pends");
    rd(2'd1, 16'h0042, "R5 warn at 96");
    counts(9'd95, 8'd96);
    rd(2'd3, 16'h0000, "R7 unchanged flags silent");
    rd(2'd2, 16'h605F, "R4 counter fields");
    counts(9'd128, 8'd0);
    rd(2'd3, 16'h8000, "R7 passive entry pends");
    rd(2'd1, 16'h0062, "R5 passive above 127");
    counts(9'd10, 8'd130);
    rd(2'd3, 16'h0000, "R7 rx passive same flags");
    rd(2'd2, 16'h820A, "R4 rx passive bit");
    rd(2'd1, 16'h0062, "R5 passive from rx");
    wr(2'd0, 8'h0E);
    counts(9'd256, 8'd0);
    rd(2'd3, 16'h8000, "R7 bus-off pends");
    rd(2'd0, 16'h000F, "R6 bus-off forces init");
    rd(2'd1, 16'h00E2, "R6 bus-off flag");
    rd(2'd2, 16'h0000, "R4 tx low byte");
    counts(9'd0, 8'd0);
    rd(2'd3, 16'h8000, "R7 recovery pends");
    rd(2'd1, 16'h0002, "R5 flags clear");
    chkIrq(1'b0, "R12 idle after ack");
    repeat (2) @(posedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule